// File: doc/BRIEF.md
# USB Device Command and Mode Engine

This block is the command-driven control core of a USB device controller. Software first writes a command code. It then writes or reads data bytes through a simple strobe handshake. The engine holds three pieces of state: the device-configured flag, a 7-bit mode word, and the 11-bit frame number taken from the most recent good start-of-frame. From these it drives the clock-request output and the active-low activity LED. It also decides, from transaction-complete pulses, which transfers raise an endpoint interrupt.

Command sequencing is a small state machine with five states:
- `ST_IDLE`: no command is open.
- `ST_MODE_WR`: waiting for the single mode data byte.
- `ST_CFG_WR`: waiting for the single configure data byte.
- `ST_FRM_LO`: the next read returns the low frame byte.
- `ST_FRM_HI`: the next read returns the high frame byte.

The transitions are:
- A command strobe moves from any state to the state for that code. An unknown code goes to `ST_IDLE`.
- A data write leaves `ST_MODE_WR` or `ST_CFG_WR` for `ST_IDLE`.
- A read moves `ST_FRM_LO` to `ST_FRM_HI`.
- A read moves `ST_FRM_HI` to `ST_IDLE`.

Top module: `usb_cmd_engine`

## Requirements
- R1: After command 0xF3, the first data write stores bits 6:0 of the byte into `mode_out`, and bit 7 is dropped. Any further data write before the next command leaves `mode_out` unchanged.
- R2: After reset:
  - `mode_out` is 0 and `cfg_out` is 0.
  - `ep_irq` and `rd_valid` are 0.
  - `up_led_n` is 1.
  - `clk_req` is 1 while `suspend` is 0.
- R3: After command `CMD_CFG` (default 0xD8), the first data write copies bit 0 of the byte into `cfg_out`. Bits 7:1 of that byte have no effect.
- R4: A `bus_reset` pulse clears `cfg_out` on the next clock edge. A bus reset has priority over a configure write in the same cycle.
- R5: `up_led_n` is 0 exactly when `cfg_out` is 1 and `suspend` is 0. Otherwise it is 1.
- R6: `clk_req` is 1 whenever `mode_out[0]` is 1 or `suspend` is 0. It is 0 when `suspend` is 1 and `mode_out[0]` is 0.
- R7: A `sof_valid` pulse latches `sof_frame`. After command 0xF5:
  - the first read returns frame[7:0];
  - the second read returns {5'b0, frame[10:8]}.
  
  Each read byte appears on `rd_data`, with `rd_valid` high, in the cycle after the `dat_rd` strobe.
- R8: The frame value returned by both reads is the one latched when the 0xF5 command was written. A start-of-frame arriving between the command and the reads does not change it.
- R9: These reads return 0x00:
  - a third or later read after 0xF5;
  - any read after an unknown command;
  - any read after 0xF3 or `CMD_CFG`.
  
  An unknown command also causes data writes to change nothing. Reading only one frame byte and then issuing a new command is allowed.
- R10: A `xfer_done` pulse with `xfer_nak` = 0 and a class code 0 to 5 produces a one-cycle `ep_irq` pulse on the next cycle. The class codes are: 0 control IN, 1 control OUT, 2 interrupt IN, 3 interrupt OUT, 4 bulk IN, 5 bulk OUT.
- R11: A `xfer_done` pulse with `xfer_nak` = 1 and class c (0 to 5) raises `ep_irq` only if `mode_out[c+1]` is 1. Class codes 6 and 7 never raise `ep_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Data write byte |
| dat_rd | input | 1 | Data read strobe |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read byte present, one cycle after dat_rd |
| sof_valid | input | 1 | Good start-of-frame pulse |
| sof_frame | input | 11 | Frame number of that start-of-frame |
| bus_reset | input | 1 | USB bus reset detected |
| suspend | input | 1 | Device is suspended |
| xfer_done | input | 1 | Transaction complete pulse |
| xfer_nak | input | 1 | The completed transaction was NAKed |
| xfer_class | input | 3 | Endpoint class code of the transaction |
| ep_irq | output | 1 | Endpoint interrupt pulse |
| clk_req | output | 1 | Request to keep the 48 MHz clock running |
| up_led_n | output | 1 | Active-low configured-and-awake LED |
| mode_out | output | 7 | Current mode word |
| cfg_out | output | 1 | Device-configured flag |

## Verification
Different kinds of internal fault show up in different ways:
- A sequencer left in the wrong state shows up on the next `dat_rd` strobe. One cycle later, `rd_data` carries the wrong frame byte or a nonzero filler.
- A misrouted data write shows on `mode_out` or `cfg_out` at the edge that takes the strobe.
- A stale snapshot shows only when a start-of-frame falls between the command and its reads, so that ordering is driven on purpose.
- A mis-indexed NAK enable shows as a missing or extra `ep_irq` one cycle after `xfer_done`. This only appears for the class whose mode bit differs from its neighbours, so alternating mode patterns are used.

// File: rtl/usb_cmd_pkg.sv
package usb_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE_WR,
        ST_CFG_WR,
        ST_FRM_LO,
        ST_FRM_HI
    } cmd_state_t;

    localparam int NUM_EP_CLASSES = 6;

endpackage

// File: rtl/usb_frame_latch.sv
module usb_frame_latch #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    output logic [FRAME_W-1:0] frame_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (sof_valid) begin
            frame_q <= sof_frame;
        end
    end

endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate #(
    parameter int NUM_CLASSES = 6,
    parameter int CLASS_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   done,
    input  logic                   nak,
    input  logic [CLASS_W-1:0]     cls,
    input  logic [NUM_CLASSES-1:0] nak_en,
    output logic                   irq
);

    logic [NUM_CLASSES-1:0] hit;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_class
        assign hit[g] = done && (cls == CLASS_W'(g)) && (!nak || nak_en[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |hit;
        end
    end

endmodule

// File: rtl/usb_cmd_seq.sv
module usb_cmd_seq
    import usb_cmd_pkg::*;
#(
    parameter logic [7:0] CMD_MODE  = 8'hF3,
    parameter logic [7:0] CMD_CFG   = 8'hD8,
    parameter logic [7:0] CMD_FRAME = 8'hF5,
    parameter int         FRAME_W   = 11,
    parameter int         MODE_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_code,
    input  logic               dat_wr,
    input  logic [7:0]         dat_wdata,
    input  logic               dat_rd,
    input  logic               bus_reset,
    input  logic [FRAME_W-1:0] frame_now,
    output logic [MODE_W-1:0]  mode_q,
    output logic               cfg_q,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);

    localparam int HI_W  = FRAME_W - 8;
    localparam int PAD_W = 8 - HI_W;

    cmd_state_t         state, state_nx;
    logic [FRAME_W-1:0] snap;
    logic [7:0]         rd_byte;

    // Next-state decode
    always_comb begin
        state_nx = state;
        if (cmd_wr) begin
            case (cmd_code)
                CMD_MODE:  state_nx = ST_MODE_WR;
                CMD_CFG:   state_nx = ST_CFG_WR;
                CMD_FRAME: state_nx = ST_FRM_LO;
                default:   state_nx = ST_IDLE;
            endcase
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_MODE_WR: if (dat_wr) state_nx = ST_IDLE;
                ST_CFG_WR:  if (dat_wr) state_nx = ST_IDLE;
                ST_FRM_LO:  if (dat_rd) state_nx = ST_FRM_HI;
                ST_FRM_HI:  if (dat_rd) state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Byte returned for a read in the current state
    always_comb begin
        unique case (state)
            ST_FRM_LO: rd_byte = snap[7:0];
            ST_FRM_HI: rd_byte = {{PAD_W{1'b0}}, snap[FRAME_W-1:8]};
            default:   rd_byte = 8'h00;
        endcase
    end

    // Outputs and held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            cfg_q    <= 1'b0;
            snap     <= '0;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= dat_rd;
            if (dat_rd) begin
                rd_data <= rd_byte;
            end
            if (cmd_wr && cmd_code == CMD_FRAME) begin
                snap <= frame_now;
            end
            if (!cmd_wr && dat_wr && state == ST_MODE_WR) begin
                mode_q <= dat_wdata[MODE_W-1:0];
            end
            if (bus_reset) begin
                cfg_q <= 1'b0;
            end else if (!cmd_wr && dat_wr && state == ST_CFG_WR) begin
                cfg_q <= dat_wdata[0];
            end
        end
    end

endmodule

// File: rtl/usb_cmd_engine.sv
module usb_cmd_engine
    import usb_cmd_pkg::*;
#(
    parameter logic [7:0] CMD_MODE  = 8'hF3,
    parameter logic [7:0] CMD_CFG   = 8'hD8,
    parameter logic [7:0] CMD_FRAME = 8'hF5,
    parameter int         FRAME_W   = 11,
    parameter int         CLASS_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_code,
    input  logic               dat_wr,
    input  logic [7:0]         dat_wdata,
    input  logic               dat_rd,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               bus_reset,
    input  logic               suspend,
    input  logic               xfer_done,
    input  logic               xfer_nak,
    input  logic [CLASS_W-1:0] xfer_class,
    output logic               ep_irq,
    output logic               clk_req,
    output logic               up_led_n,
    output logic [NUM_EP_CLASSES:0] mode_out,
    output logic               cfg_out
);

    localparam int MODE_W = NUM_EP_CLASSES + 1;

    logic [FRAME_W-1:0] frame_q;

    usb_frame_latch #(.FRAME_W(FRAME_W)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_valid (sof_valid),
        .sof_frame (sof_frame),
        .frame_q   (frame_q)
    );

    usb_cmd_seq #(
        .CMD_MODE  (CMD_MODE),
        .CMD_CFG   (CMD_CFG),
        .CMD_FRAME (CMD_FRAME),
        .FRAME_W   (FRAME_W),
        .MODE_W    (MODE_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_code  (cmd_code),
        .dat_wr    (dat_wr),
        .dat_wdata (dat_wdata),
        .dat_rd    (dat_rd),
        .bus_reset (bus_reset),
        .frame_now (frame_q),
        .mode_q    (mode_out),
        .cfg_q     (cfg_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    usb_irq_gate #(
        .NUM_CLASSES (NUM_EP_CLASSES),
        .CLASS_W     (CLASS_W)
    ) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (xfer_done),
        .nak    (xfer_nak),
        .cls    (xfer_class),
        .nak_en (mode_out[MODE_W-1:1]),
        .irq    (ep_irq)
    );

    assign clk_req  = mode_out[0] || !suspend;
    assign up_led_n = !(cfg_out && !suspend);

endmodule

// File: rtl/usb_cmd_engine_chk.sv
module usb_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        dat_wr,
    input logic        dat_rd,
    input logic        rd_valid,
    input logic        bus_reset,
    input logic        suspend,
    input logic        xfer_done,
    input logic        xfer_nak,
    input logic [2:0]  xfer_class,
    input logic        ep_irq,
    input logic        clk_req,
    input logic        up_led_n,
    input logic [6:0]  mode_out,
    input logic        cfg_out
);

    // R1: mode word moves only on a data write
    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> $stable(mode_out));

    // R4: bus reset clears the configured flag
    assert_cfg_bus_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !cfg_out);

    // R5: LED lit only when configured and awake
    assert_led_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !up_led_n |-> (cfg_out && !suspend));

    // R6: clock request held while awake or always-clock set
    assert_clk_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out[0] || !suspend) |-> clk_req);

    // R7: each read strobe yields a read byte next cycle
    assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd |=> rd_valid);

    // R10: interrupt only follows a done pulse
    assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> $past(xfer_done));

    // R10: successful transfer of a valid class always interrupts
    assert_good_done_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !xfer_nak && xfer_class < 3'd6) |=> ep_irq);

    // R11: masked NAK and invalid classes stay silent
    assert_nak_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_nak && xfer_class < 3'd6 &&
         !mode_out[{1'b0, xfer_class} + 4'd1]) |=> !ep_irq);

    assert_bad_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_class >= 3'd6) |=> !ep_irq);

endmodule

bind usb_cmd_engine usb_cmd_engine_chk i_chk (.*);

// File: tb/test_usb_cmd_engine.sv
`timescale 1ns/1ps
module test_usb_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        dat_wr = 1'b0;
    logic [7:0]  dat_wdata = 8'h00;
    logic        dat_rd = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = 11'h0;
    logic        bus_reset = 1'b0;
    logic        suspend = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_nak = 1'b0;
    logic [2:0]  xfer_class = 3'd0;
    logic        ep_irq;
    logic        clk_req;
    logic        up_led_n;
    logic [6:0]  mode_out;
    logic        cfg_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    usb_cmd_engine i_usb_cmd_engine (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk); cmd_wr = 1'b1; cmd_code = code;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = d;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic sof(input logic [10:0] f);
        @(negedge clk); sof_valid = 1'b1; sof_frame = f;
        @(negedge clk); sof_valid = 1'b0;
    endtask

    task automatic xfer(input logic [2:0] cls, input logic nak, input logic exp, input string tag);
        @(negedge clk); xfer_done = 1'b1; xfer_nak = nak; xfer_class = cls;
        @(negedge clk); xfer_done = 1'b0;
        check(tag, 16'(ep_irq), 16'(exp));
        @(negedge clk);
        check({tag, " pulse"}, 16'(ep_irq), 16'h0);
    endtask

    // Scoreboard monitor for read bytes
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7: unexpected read 0x%0h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), 16'(rd_data), 16'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 mode", 16'(mode_out), 16'h0);
        check("R2 cfg", 16'(cfg_out), 16'h0);
        check("R2 irq", 16'(ep_irq), 16'h0);
        check("R2 led", 16'(up_led_n), 16'h1);
        check("R2 clkreq", 16'(clk_req), 16'h1);
        check("R2 rdvalid", 16'(rd_valid), 16'h0);

        // R1 mode write, bit 7 dropped, extra write ignored
        send_cmd(8'hF3); wr_byte(8'hA5);
        check("R1 mode", 16'(mode_out), 16'h25);
        wr_byte(8'h00);
        check("R1 extra write", 16'(mode_out), 16'h25);
        rd_byte(8'h00, "R9 read after mode");

        // R6 always-clock holds request in suspend
        @(negedge clk); suspend = 1'b1;
        @(negedge clk);
        check("R6 always clk", 16'(clk_req), 16'h1);
        suspend = 1'b0;

        // R11 NAK gating with mode 0x25 (bits 2,5 enable ctrl OUT, bulk IN)
        xfer(3'd1, 1'b1, 1'b1, "R11 ctrl OUT nak");
        xfer(3'd0, 1'b1, 1'b0, "R11 ctrl IN nak");
        xfer(3'd4, 1'b1, 1'b1, "R11 bulk IN nak");
        xfer(3'd5, 1'b1, 1'b0, "R11 bulk OUT nak");
        xfer(3'd6, 1'b0, 1'b0, "R11 class 6");
        xfer(3'd7, 1'b1, 1'b0, "R11 class 7");
        // R10 successful transfers
        xfer(3'd3, 1'b0, 1'b1, "R10 int OUT ok");
        xfer(3'd0, 1'b0, 1'b1, "R10 ctrl IN ok");

        // R3 configure, upper bits ignored
        send_cmd(8'hD8); wr_byte(8'hFE);
        check("R3 cfg bit0 clear", 16'(cfg_out), 16'h0);
        send_cmd(8'hD8); wr_byte(8'h01);
        check("R3 cfg set", 16'(cfg_out), 16'h1);
        check("R5 led on", 16'(up_led_n), 16'h0);
        @(negedge clk); suspend = 1'b1;
        @(negedge clk);
        check("R5 led suspended", 16'(up_led_n), 16'h1);
        suspend = 1'b0;
        @(negedge clk);
        check("R5 led back", 16'(up_led_n), 16'h0);

        // R4 bus reset
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        check("R4 cfg cleared", 16'(cfg_out), 16'h0);
        check("R4 led off", 16'(up_led_n), 16'h1);
        // R4 priority over configure write
        send_cmd(8'hD8);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = 8'h01; bus_reset = 1'b1;
        @(negedge clk); dat_wr = 1'b0; bus_reset = 1'b0;
        check("R4 priority", 16'(cfg_out), 16'h0);

        // R7 frame readback
        sof(11'h5A3);
        send_cmd(8'hF5);
        rd_byte(8'hA3, "R7 low byte");
        rd_byte(8'h05, "R7 high byte");
        rd_byte(8'h00, "R9 third read");

        // R8 snapshot at command time
        sof(11'h123);
        send_cmd(8'hF5);
        sof(11'h7FF);
        rd_byte(8'h23, "R8 low byte");
        rd_byte(8'h01, "R8 high byte");

        // R9 single-byte read, then new command
        send_cmd(8'hF5);
        rd_byte(8'hFF, "R9 single read");
        send_cmd(8'hF3); wr_byte(8'h00);
        check("R1 mode cleared", 16'(mode_out), 16'h0);
        xfer(3'd1, 1'b1, 1'b0, "R11 ctrl OUT nak masked");

        // R6 clock may drop in suspend
        @(negedge clk); suspend = 1'b1;
        @(negedge clk);
        check("R6 clk drop", 16'(clk_req), 16'h0);
        suspend = 1'b0;

        // R9 unknown command
        send_cmd(8'h42);
        wr_byte(8'h7F);
        check("R9 unknown write", 16'(mode_out), 16'h0);
        check("R9 unknown cfg", 16'(cfg_out), 16'h0);
        rd_byte(8'h00, "R9 unknown read");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R7: actual %0d reads missing expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule